// File: doc/BRIEF.md
# Indexed Performance Counter Unit

This block holds a bank of event counters behind a small register interface with one write port and a combinational read port. Software first writes the number of a counter into an index register. The count, snapshot and condition-select registers then all act on that counter through shared addresses. Each counter has a condition code that picks one line of the `events` input. While the unit runs, the counter adds one on every cycle in which that event line is high. Condition 0 never fires, so writing 0 to a counter's condition select stops that counter.

One control register covers the whole bank. It starts or stops every counter at once, clears all counts, and copies the selected counter into a shared snapshot register pair. Software then reads that pair in two accesses without seeing a torn value. Two read-only build registers report the version, the number of counters, the counter width code and the number of conditions. A name table returns an 8-character ASCII name for each condition, selected by its own index register.

Global run state is a two-state machine. In `ST_HALT` nothing counts. A control write with bit 0 set takes the transition `halt_to_count` into `ST_COUNT`. A control write with bit 0 clear takes `count_to_halt` back to `ST_HALT`. Any other access leaves the state where it is. Reset enters `ST_HALT`.

Top module: `perf_ctr_unit`

## Requirements
- R1: After reset every count, the snapshot, the counter index, the name index and every condition select are 0, and the control register at address 6 reads 0.
- R2: The counter build register (address 7) reads version 1 in [7:0], width code S in [9:8] and the counter count in [23:16], all other bits 0. Its default value is 0x00040101. The condition build register (address 8) reads version 1 in [7:0] and the condition count in [31:16]. Its default value is 0x00080001.
- R3: While running, a counter adds one on each clock edge at which the event line named by its condition select (address 5) is high. A condition select of 0 never counts, even with every event line high.
- R4: A control write sets the run state from data bit 0, and control bit 0 reads back that state. While halted, no counter changes, whatever the events do.
- R5: A control write with bit 16 set zeroes every counter. Bits 16 and 17 always read back as 0.
- R6: A control write with bit 17 set copies the selected counter, as it stood before that edge, into the snapshot registers. Snapshot low is at address 3 and snapshot high at address 4. The snapshot then holds while the counter moves on. The same write still updates the run state from bit 0.
- R7: Count low (address 1) and count high (address 2) can be written directly. The high word keeps only its lower W−32 bits, where W = 32 + 16·S (48 by default). A counter wraps to 0 after its all-ones value.
- R8: The index register (address 0) selects which counter the addresses 1 to 5 reach. Each counter keeps its own condition select and count.
- R9: When the index is at or above the counter count, addresses 1 to 5 read 0, and writes to them change no counter, no condition select and no snapshot.
- R10: Writing a condition number to address 9 makes addresses 10 and 11 return its name, with character 0 in bits [7:0] of address 10 and character 4 in bits [7:0] of address 11. Condition 1 is "crun" and condition 3 is "bpfail". A number at or above the condition count returns 0 in both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for reg_addr/reg_wdata |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| events | input | NUM_COND | Event lines, one per condition code |

## Verification
The bench holds a single event line high for a known number of edges, and the count must equal that number exactly. This separates a correct increment from an off-by-one. It then raises every event line at once, with one counter on condition 0 and the unit halted, which separates the never condition and the halt state from a plain event gate. An all-ones preload followed by one event edge exposes carry and wrap faults across the split low and high words. Snapshot, clear and out-of-range accesses are each followed by readbacks of both the selected counter and its neighbours, so a write that lands on the wrong counter also shows up.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam logic [3:0] A_IDX  = 4'd0;
    localparam logic [3:0] A_CLO  = 4'd1;
    localparam logic [3:0] A_CHI  = 4'd2;
    localparam logic [3:0] A_SLO  = 4'd3;
    localparam logic [3:0] A_SHI  = 4'd4;
    localparam logic [3:0] A_CSEL = 4'd5;
    localparam logic [3:0] A_CTRL = 4'd6;
    localparam logic [3:0] A_CBLD = 4'd7;
    localparam logic [3:0] A_NBLD = 4'd8;
    localparam logic [3:0] A_NIDX = 4'd9;
    localparam logic [3:0] A_NAM0 = 4'd10;
    localparam logic [3:0] A_NAM1 = 4'd11;

    localparam int RUN_BIT  = 0;
    localparam int CLR_BIT  = 16;
    localparam int SNAP_BIT = 17;

    typedef enum logic {ST_HALT = 1'b0, ST_COUNT = 1'b1} run_state_e;

    // Left-justify a right-aligned literal, then reverse bytes so char 0 sits at [7:0]
    function automatic logic [63:0] pack_name(input logic [63:0] lit);
        logic [63:0] t;
        logic [63:0] r;
        t = lit;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            if (t[63:56] == 8'h00 && t != '0) t = t << 8;
        end
        for (int k = 0; k < 8; k++) begin
            r[8*k +: 8] = t[63-8*k -: 8];
        end
        return r;
    endfunction

    function automatic logic [63:0] cond_name(input logic [7:0] n);
        logic [63:0] lit;
        case (n)
            8'd0:    lit = 64'("never");
            8'd1:    lit = 64'("crun");
            8'd2:    lit = 64'("iall");
            8'd3:    lit = 64'("bpfail");
            8'd4:    lit = 64'("ijmp");
            8'd5:    lit = 64'("bstall");
            8'd6:    lit = 64'("bflush");
            8'd7:    lit = 64'("dclm");
            default: lit = '0;
        endcase
        return pack_name(lit);
    endfunction

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
    import pcu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic [31:0] wdata,
    output logic        run,
    output logic        clr_pulse,
    output logic        snap_pulse
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (ctrl_we &&  wdata[RUN_BIT]) state_d = ST_COUNT; // halt_to_count
            ST_COUNT: if (ctrl_we && !wdata[RUN_BIT]) state_d = ST_HALT;  // count_to_halt
            default:  state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run        = (state_q == ST_COUNT);
        clr_pulse  = ctrl_we & wdata[CLR_BIT];
        snap_pulse = ctrl_we & wdata[SNAP_BIT];
    end

    // R4
    run_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (run == $past(wdata[RUN_BIT])));

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(run));

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [31:0]  wdata,
    output logic [W-1:0] value
);

    logic [W-1:0] cnt_q, cnt_d;
    logic [63:0]  wide, upd;

    always_comb begin
        wide = 64'(cnt_q);
        upd  = wide;
        if (wr_lo) upd[31:0]  = wdata;
        if (wr_hi) upd[63:32] = wdata;
        if (clr)                 cnt_d = '0;
        else if (wr_lo || wr_hi) cnt_d = upd[W-1:0];
        else if (inc)            cnt_d = cnt_q + W'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));

    // R3
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !wr_lo && !wr_hi) |=> (value == $past(value) + W'(1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr && !wr_lo && !wr_hi) |=> $stable(value));

endmodule

// File: rtl/pcu_names.sv
module pcu_names
    import pcu_pkg::*;
#(
    parameter int NUM_COND = 8
) (
    input  logic [7:0]  nidx,
    output logic [31:0] name0,
    output logic [31:0] name1
);

    logic [63:0] nm;

    always_comb begin
        if (32'(nidx) < NUM_COND) nm = cond_name(nidx);
        else                      nm = '0;
        name0 = nm[31:0];
        name1 = nm[63:32];
    end

endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
    import pcu_pkg::*;
#(
    parameter int NUM_CTR   = 4,
    parameter int SIZE_CODE = 1,
    parameter int NUM_COND  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [3:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_COND-1:0] events
);

    localparam int W      = 32 + 16 * SIZE_CODE;
    localparam int SEL_W  = (NUM_CTR  > 1) ? $clog2(NUM_CTR)  : 1;
    localparam int CSEL_W = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

    logic [7:0]        idx_q, nidx_q;
    logic [CSEL_W-1:0] csel_q [NUM_CTR];
    logic [W-1:0]      val    [NUM_CTR];
    logic [W-1:0]      snap_q;
    logic              run, clr_pulse, snap_pulse;
    logic              sel_ok;
    logic [SEL_W-1:0]  sel;
    logic [W-1:0]      sel_val;
    logic [31:0]       name0, name1;
    logic [63:0]       sel_wide, snap_wide;

    assign sel_ok  = (32'(idx_q) < NUM_CTR);
    assign sel     = idx_q[SEL_W-1:0];
    assign sel_val = sel_ok ? val[sel] : '0;

    pcu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (reg_we && reg_addr == A_CTRL),
        .wdata      (reg_wdata),
        .run        (run),
        .clr_pulse  (clr_pulse),
        .snap_pulse (snap_pulse)
    );

    pcu_names #(.NUM_COND(NUM_COND)) u_names (
        .nidx  (nidx_q),
        .name0 (name0),
        .name1 (name1)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            nidx_q <= '0;
            snap_q <= '0;
        end else begin
            if (reg_we && reg_addr == A_IDX)  idx_q  <= reg_wdata[7:0];
            if (reg_we && reg_addr == A_NIDX) nidx_q <= reg_wdata[7:0];
            if (snap_pulse && sel_ok)         snap_q <= sel_val;
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic hit, inc, fire;

        assign hit  = sel_ok && (32'(sel) == i);
        assign fire = (csel_q[i] != '0) && (32'(csel_q[i]) < NUM_COND)
                      && events[csel_q[i]];
        assign inc  = run && fire;

        always_ff @(posedge clk) begin
            if (!rst_n)                                 csel_q[i] <= '0;
            else if (reg_we && reg_addr == A_CSEL && hit) csel_q[i] <= reg_wdata[CSEL_W-1:0];
        end

        pcu_counter #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_pulse),
            .inc   (inc),
            .wr_lo (reg_we && reg_addr == A_CLO && hit),
            .wr_hi (reg_we && reg_addr == A_CHI && hit),
            .wdata (reg_wdata),
            .value (val[i])
        );

        // R3
        never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (csel_q[i] == '0 && !reg_we) |=> $stable(val[i]));
    end

    always_comb begin
        sel_wide  = 64'(sel_val);
        snap_wide = sel_ok ? 64'(snap_q) : '0;
        case (reg_addr)
            A_IDX:   reg_rdata = 32'(idx_q);
            A_CLO:   reg_rdata = sel_wide[31:0];
            A_CHI:   reg_rdata = sel_wide[63:32];
            A_SLO:   reg_rdata = snap_wide[31:0];
            A_SHI:   reg_rdata = snap_wide[63:32];
            A_CSEL:  reg_rdata = sel_ok ? 32'(csel_q[sel]) : '0;
            A_CTRL:  reg_rdata = {31'd0, run};
            A_CBLD:  reg_rdata = {8'h00, 8'(NUM_CTR), 6'd0, 2'(SIZE_CODE), 8'h01};
            A_NBLD:  reg_rdata = {16'(NUM_COND), 8'h00, 8'h01};
            A_NIDX:  reg_rdata = 32'(nidx_q);
            A_NAM0:  reg_rdata = name0;
            A_NAM1:  reg_rdata = name1;
            default: reg_rdata = '0;
        endcase
    end

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(snap_pulse && sel_ok) |=> $stable(snap_q));

    // R9
    range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && reg_addr == A_CLO) |-> (reg_rdata == '0));

endmodule

// File: tb/sim_perf_ctr_unit.sv
module sim_perf_ctr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  events = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    perf_ctr_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_events(input logic [7:0] pat, input int n);
        @(negedge clk);
        events = pat;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d);  chk("R1 index", d, 0);
        rd(4'd6, d);  chk("R1 control", d, 0);
        rd(4'd1, d);  chk("R1 count low", d, 0);
        rd(4'd3, d);  chk("R1 snapshot low", d, 0);
        rd(4'd5, d);  chk("R1 condition select", d, 0);
        rd(4'd9, d);  chk("R1 name index", d, 0);
    endtask

    task automatic t_build();
        logic [31:0] d;
        rd(4'd7, d); chk("R2 counter build", d, 32'h0004_0101);
        rd(4'd8, d); chk("R2 condition build", d, 32'h0008_0001);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(4'd0, 0); wr(4'd5, 1);
        wr(4'd0, 1); wr(4'd5, 0);
        wr(4'd6, 1);
        rd(4'd6, d); chk("R4 control reads running", d, 1);
        pulse_events(8'h02, 5);
        wr(4'd0, 0);
        rd(4'd1, d); chk("R3 five event cycles", d, 5);
        pulse_events(8'hFF, 4);
        rd(4'd1, d); chk("R8 counter0 on cond1", d, 9);
        wr(4'd0, 1);
        rd(4'd1, d); chk("R3 cond0 never counts", d, 0);
        rd(4'd5, d); chk("R8 counter1 own select", d, 0);
        wr(4'd0, 0);
        rd(4'd5, d); chk("R8 counter0 own select", d, 1);
    endtask

    task automatic t_halt();
        logic [31:0] d;
        wr(4'd6, 0);
        rd(4'd6, d); chk("R4 control reads halted", d, 0);
        pulse_events(8'hFF, 3);
        rd(4'd1, d); chk("R4 halted holds count", d, 9);
    endtask

    task automatic t_snap();
        logic [31:0] d;
        wr(4'd6, 32'h0002_0001);
        rd(4'd3, d); chk("R6 snapshot low", d, 9);
        rd(4'd4, d); chk("R6 snapshot high", d, 0);
        rd(4'd6, d); chk("R6 run kept and bit17 reads 0", d, 1);
        pulse_events(8'h02, 2);
        rd(4'd1, d); chk("R6 counter moves on", d, 11);
        rd(4'd3, d); chk("R6 snapshot holds", d, 9);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(4'd0, 2);
        wr(4'd2, 32'hABCD_1234);
        rd(4'd2, d); chk("R7 high word width", d, 32'h0000_1234);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd2, 32'h0000_FFFF);
        rd(4'd1, d); chk("R7 write low", d, 32'hFFFF_FFFF);
        wr(4'd5, 3);
        pulse_events(8'h08, 1);
        rd(4'd1, d); chk("R7 wrap low", d, 0);
        rd(4'd2, d); chk("R7 wrap high", d, 0);
        wr(4'd1, 7);
    endtask

    task automatic t_range();
        logic [31:0] d;
        wr(4'd0, 5);
        rd(4'd0, d); chk("R9 index stored", d, 5);
        rd(4'd1, d); chk("R9 out of range reads 0", d, 0);
        wr(4'd1, 32'h55);
        wr(4'd5, 2);
        wr(4'd6, 32'h0002_0001);
        rd(4'd3, d); chk("R9 snapshot read 0", d, 0);
        wr(4'd0, 0);
        rd(4'd1, d); chk("R9 counter0 untouched", d, 11);
        rd(4'd3, d); chk("R9 snapshot untouched", d, 9);
        wr(4'd0, 1);
        rd(4'd1, d); chk("R9 counter1 untouched", d, 0);
        rd(4'd5, d); chk("R9 select untouched", d, 0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(4'd6, 32'h0001_0001);
        rd(4'd6, d); chk("R5 bit16 reads 0", d, 1);
        wr(4'd0, 0);
        rd(4'd1, d); chk("R5 counter0 cleared", d, 0);
        wr(4'd0, 2);
        rd(4'd1, d); chk("R5 counter2 cleared", d, 0);
    endtask

    task automatic t_names();
        logic [31:0] d;
        wr(4'd9, 1);
        rd(4'd10, d); chk("R10 crun word0", d, 32'h6E75_7263);
        rd(4'd11, d); chk("R10 crun word1", d, 0);
        wr(4'd9, 3);
        rd(4'd10, d); chk("R10 bpfail word0", d, 32'h6166_7062);
        rd(4'd11, d); chk("R10 bpfail word1", d, 32'h0000_6C69);
        wr(4'd9, 9);
        rd(4'd10, d); chk("R10 out of range", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_build();
        t_count();
        t_halt();
        t_snap();
        t_wrap();
        t_range();
        t_clear();
        t_names();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule